// File: doc/BRIEF.md
# Flash Bank Mode Controller with Reset Command Handling

This block follows the operating mode of every bank of a multi-bank flash array and decides what a reset command does to each of them. Decoded bus writes arrive as a command code with a target bank. The controller walks each bank through its unlock and setup cycles for program, erase and identification (autoselect). It starts a busy phase when a sequence completes, and it returns the bank to its home mode on a reset, on an aborted sequence or on completion. The embedded program and erase algorithms are outside the block. Each bank is modelled by a per-bank done pulse and a per-bank timeout status bit.

A reset is a broadcast command. The target bank field is ignored, and every bank judges the reset by its own state. A bank part-way through a command sequence drops back to its home mode. A bank in identification mode leaves it. A bank with an embedded operation running ignores the reset, unless its timeout bit reports a failure. The home mode is read, or erase-suspend-read for a bank whose erase is suspended. Any command that a busy bank has to drop raises a one-cycle ignored flag.

Per bank, the states are READ, SUSP_READ, SEQ, AUTOSEL, PGM_BUSY and ERS_BUSY. The transitions are:
- unlock-start: READ or SUSP_READ to SEQ.
- seq-advance: SEQ to SEQ.
- seq-abort and reset-home: SEQ to home.
- id-enter: SEQ to AUTOSEL.
- id-exit: AUTOSEL to home.
- pgm-start: SEQ to PGM_BUSY.
- ers-start: SEQ to ERS_BUSY.
- pgm-done and fail-reset: PGM_BUSY to home.
- ers-done and fail-reset: ERS_BUSY to READ.
- suspend: ERS_BUSY to SUSP_READ.
- resume: SUSP_READ to ERS_BUSY.

Top module: `flash_bank_mode_ctl`

## Requirements
- R1: After reset every bank reports mode READ and cmd_ignored is 0. Mode codes are READ=0, SUSP_READ=1, SEQ=2, AUTOSEL=3, PGM_BUSY=4 and ERS_BUSY=5, and no other code ever appears. Bank i occupies bank_mode[3i+2:3i].
- R2: A command with code 0 (reset) applies to every bank whatever cmd_bank holds. It returns every bank in SEQ to its home mode: SUSP_READ if that bank is suspended, READ otherwise.
- R3: The codes 1 (unlock A), 2 (unlock B), 3 (program setup) and 6 (data write) move the target bank to SEQ after the first of them and to PGM_BUSY after the last. A reset at any point before the data write returns the bank to its home mode.
- R4: The codes 1, 2, 4 (erase setup), 1, 2 and 6 move the target bank to ERS_BUSY. A reset before the last cycle returns the bank to home.
- R5: The codes 1, 2 and 5 (identify setup) put the target bank in AUTOSEL. It stays there under any other command and leaves only on a reset, to its home mode.
- R6: A bank in PGM_BUSY or ERS_BUSY whose done bit is low drops a reset when its timeout bit is low. It also drops any other command aimed at it, except a suspend sent to an erasing bank. Its mode is unchanged, and cmd_ignored is 1 for exactly the cycle after that command.
- R7: A reset while a busy bank's timeout bit is high returns that bank to home: SUSP_READ for a program started from suspend, READ otherwise.
- R8: Code 7 (suspend) sent to a bank in ERS_BUSY gives SUSP_READ. Code 8 (resume) sent to a bank in SUSP_READ gives ERS_BUSY. A done pulse in ERS_BUSY gives READ and clears the suspension.
- R9: A done pulse in PGM_BUSY returns the bank to its home mode.
- R10: In SEQ, a code that is not the expected next cycle aborts to home. Erase setup is not accepted in a suspended bank.
- R11: A command aimed at one bank leaves the mode of every other bank unchanged, with the reset broadcast as the only exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 4 | Decoded command code |
| cmd_bank | input | BANK_W (2) | Target bank of the command |
| op_done | input | NUM_BANKS (4) | Per-bank embedded operation complete pulse |
| op_timeout | input | NUM_BANKS (4) | Per-bank embedded operation timeout status |
| bank_mode | output | 3*NUM_BANKS (12) | Packed per-bank mode codes |
| cmd_ignored | output | 1 | A command was dropped by a busy bank last cycle |

## Verification
Every result is registered once. A command or done pulse sampled on a rising edge shows up in bank_mode and cmd_ignored right after that same edge, and cmd_ignored drops back on the following edge. The bench drives inputs on falling edges and steps a behavioural reference model on each rising edge. It compares all bank modes and the ignored flag on every falling edge, so each result is read half a cycle after the edge that produced it. Directed checks at the same falling edges confirm the values each requirement predicts, including the ignored pulse and its removal one cycle later.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
    localparam int MODE_W = 3;
    localparam int CMD_W  = 4;
    localparam int CNT_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_READ      = 3'd0,
        MODE_SUSP_READ = 3'd1,
        MODE_SEQ       = 3'd2,
        MODE_AUTOSEL   = 3'd3,
        MODE_PGM_BUSY  = 3'd4,
        MODE_ERS_BUSY  = 3'd5
    } bank_mode_e;

    localparam logic [CMD_W-1:0] OP_RESET         = 4'd0;
    localparam logic [CMD_W-1:0] OP_UNLOCK_A      = 4'd1;
    localparam logic [CMD_W-1:0] OP_UNLOCK_B      = 4'd2;
    localparam logic [CMD_W-1:0] OP_PROG_SETUP    = 4'd3;
    localparam logic [CMD_W-1:0] OP_ERASE_SETUP   = 4'd4;
    localparam logic [CMD_W-1:0] OP_AUTOSEL_SETUP = 4'd5;
    localparam logic [CMD_W-1:0] OP_WRITE_DATA    = 4'd6;
    localparam logic [CMD_W-1:0] OP_SUSPEND       = 4'd7;
    localparam logic [CMD_W-1:0] OP_RESUME        = 4'd8;

    typedef enum logic [1:0] {
        SEQ_NONE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2
    } seq_kind_e;
endpackage

// File: rtl/fbm_cmd_route.sv
module fbm_cmd_route
    import fbm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 cmd_valid,
    input  logic [CMD_W-1:0]     cmd_code,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 any_reset
);
    assign any_reset = cmd_valid && (cmd_code == OP_RESET);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_hit
        assign bank_hit[i] = cmd_valid && (cmd_code != OP_RESET) &&
                             (cmd_bank == BANK_W'(i));
    end
endmodule

// File: rtl/fbm_bank_fsm.sv
module fbm_bank_fsm
    import fbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             any_reset,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             done,
    input  logic             timeout,
    output bank_mode_e       mode,
    output logic             drop
);
    bank_mode_e             mode_q, mode_d;
    seq_kind_e              kind_q, kind_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic                   susp_q, susp_d;
    bank_mode_e             home;

    assign home = susp_q ? MODE_SUSP_READ : MODE_READ;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_READ;
            kind_q <= SEQ_NONE;
            cnt_q  <= '0;
            susp_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            kind_q <= kind_d;
            cnt_q  <= cnt_d;
            susp_q <= susp_d;
        end
    end

    // next-state
    always_comb begin
        mode_d = mode_q;
        kind_d = kind_q;
        cnt_d  = cnt_q;
        susp_d = susp_q;
        unique case (mode_q)
            MODE_READ, MODE_SUSP_READ: begin
                if (hit && cmd_code == OP_UNLOCK_A) begin          // unlock-start
                    mode_d = MODE_SEQ;
                    cnt_d  = CNT_W'(1);
                    kind_d = SEQ_NONE;
                end else if (hit && cmd_code == OP_RESUME &&
                             mode_q == MODE_SUSP_READ) begin      // resume
                    mode_d = MODE_ERS_BUSY;
                    susp_d = 1'b0;
                end
            end
            MODE_SEQ: begin
                if (any_reset) begin                               // reset-home
                    mode_d = home;
                    cnt_d  = '0;
                    kind_d = SEQ_NONE;
                end else if (hit) begin
                    if (cnt_q == CNT_W'(1) && cmd_code == OP_UNLOCK_B) begin
                        cnt_d = CNT_W'(2);
                    end else if (cnt_q == CNT_W'(2) && cmd_code == OP_PROG_SETUP) begin
                        cnt_d  = CNT_W'(3);
                        kind_d = SEQ_PROG;
                    end else if (cnt_q == CNT_W'(2) && cmd_code == OP_ERASE_SETUP &&
                                 !susp_q) begin
                        cnt_d  = CNT_W'(3);
                        kind_d = SEQ_ERASE;
                    end else if (cnt_q == CNT_W'(2) && cmd_code == OP_AUTOSEL_SETUP) begin
                        mode_d = MODE_AUTOSEL;                     // id-enter
                        cnt_d  = '0;
                    end else if (cnt_q == CNT_W'(3) && kind_q == SEQ_PROG &&
                                 cmd_code == OP_WRITE_DATA) begin
                        mode_d = MODE_PGM_BUSY;                    // pgm-start
                        cnt_d  = '0;
                        kind_d = SEQ_NONE;
                    end else if (cnt_q == CNT_W'(3) && kind_q == SEQ_ERASE &&
                                 cmd_code == OP_UNLOCK_A) begin
                        cnt_d = CNT_W'(4);
                    end else if (cnt_q == CNT_W'(4) && cmd_code == OP_UNLOCK_B) begin
                        cnt_d = CNT_W'(5);
                    end else if (cnt_q == CNT_W'(5) && cmd_code == OP_WRITE_DATA) begin
                        mode_d = MODE_ERS_BUSY;                    // ers-start
                        cnt_d  = '0;
                        kind_d = SEQ_NONE;
                    end else begin                                 // seq-abort
                        mode_d = home;
                        cnt_d  = '0;
                        kind_d = SEQ_NONE;
                    end
                end
            end
            MODE_AUTOSEL: begin
                if (any_reset) mode_d = home;                      // id-exit
            end
            MODE_PGM_BUSY: begin
                if (done || (any_reset && timeout)) mode_d = home; // pgm-done / fail-reset
            end
            MODE_ERS_BUSY: begin
                if (done || (any_reset && timeout)) begin          // ers-done / fail-reset
                    mode_d = MODE_READ;
                    susp_d = 1'b0;
                end else if (hit && cmd_code == OP_SUSPEND) begin  // suspend
                    mode_d = MODE_SUSP_READ;
                    susp_d = 1'b1;
                end
            end
            default: mode_d = MODE_READ;
        endcase
    end

    // outputs
    always_comb begin
        mode = mode_q;
        drop = 1'b0;
        unique case (mode_q)
            MODE_PGM_BUSY: drop = !done && ((any_reset && !timeout) || hit);
            MODE_ERS_BUSY: drop = !done && ((any_reset && !timeout) ||
                                            (hit && cmd_code != OP_SUSPEND));
            default:       drop = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_bank_mode_ctl.sv
module flash_bank_mode_ctl
    import fbm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [CMD_W-1:0]            cmd_code,
    input  logic [BANK_W-1:0]           cmd_bank,
    input  logic [NUM_BANKS-1:0]        op_done,
    input  logic [NUM_BANKS-1:0]        op_timeout,
    output logic [NUM_BANKS*MODE_W-1:0] bank_mode,
    output logic                        cmd_ignored
);
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_BANKS-1:0] bank_drop;
    logic                 any_reset;

    fbm_cmd_route #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) route_i (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_bank  (cmd_bank),
        .bank_hit  (bank_hit),
        .any_reset (any_reset)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        bank_mode_e mode_w;
        fbm_bank_fsm fsm_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (bank_hit[i]),
            .any_reset (any_reset),
            .cmd_code  (cmd_code),
            .done      (op_done[i]),
            .timeout   (op_timeout[i]),
            .mode      (mode_w),
            .drop      (bank_drop[i])
        );
        assign bank_mode[i*MODE_W +: MODE_W] = mode_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_ignored <= 1'b0;
        else        cmd_ignored <= |bank_drop;
    end
endmodule

// File: rtl/fbm_chk.sv
module fbm_chk
    import fbm_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic [CMD_W-1:0]            cmd_code,
    input logic [NUM_BANKS-1:0]        op_done,
    input logic [NUM_BANKS-1:0]        op_timeout,
    input logic [NUM_BANKS*MODE_W-1:0] bank_mode,
    input logic                        cmd_ignored
);
    logic rst_cmd;
    assign rst_cmd = cmd_valid && (cmd_code == OP_RESET);

    AST_IGNORED_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ignored |-> $past(cmd_valid)); // R6

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
        logic [MODE_W-1:0] m;
        assign m = bank_mode[i*MODE_W +: MODE_W];

        AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            m <= 3'd5); // R1

        AST_RESET_LEAVES_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
            rst_cmd |=> m != 3'd2); // R2

        AST_AUTOSEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd3 && !rst_cmd) |=> m == 3'd3); // R5

        AST_PGM_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd4 && !op_done[i] && !(rst_cmd && op_timeout[i])) |=> m == 3'd4); // R6

        AST_PGM_DONE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd4 && op_done[i]) |=> (m == 3'd0 || m == 3'd1)); // R9

        AST_ERS_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd5 && op_done[i]) |=> m == 3'd0); // R8
    end
endmodule

bind flash_bank_mode_ctl fbm_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .op_done     (op_done),
    .op_timeout  (op_timeout),
    .bank_mode   (bank_mode),
    .cmd_ignored (cmd_ignored)
);

// File: tb/flash_bank_mode_ctl_tb_top.sv
module flash_bank_mode_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic [3:0]  op_done = 4'd0;
    logic [3:0]  op_timeout = 4'd0;
    logic [11:0] bank_mode;
    logic        cmd_ignored;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    cmp_en = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_bank_mode_ctl #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .op_done(op_done), .op_timeout(op_timeout),
        .bank_mode(bank_mode), .cmd_ignored(cmd_ignored)
    );

    // behavioural reference: 0 read,1 susp-read,2 seq,3 id,4 pgm busy,5 ers busy
    int m_mode[NB];
    int m_susp[NB];
    int m_step[NB];
    int m_what[NB];  // 0 none, 1 program, 2 erase
    int m_ign;

    initial for (int b = 0; b < NB; b++) begin
        m_mode[b] = 0; m_susp[b] = 0; m_step[b] = 0; m_what[b] = 0;
    end
    initial m_ign = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_mode[b] = 0; m_susp[b] = 0; m_step[b] = 0; m_what[b] = 0;
            end
            m_ign = 0;
        end else begin
            automatic int dropped = 0;
            automatic bit is_rst = cmd_valid && cmd_code == 4'd0;
            for (int b = 0; b < NB; b++) begin
                automatic bit mine = cmd_valid && cmd_code != 4'd0 && int'(cmd_bank) == b;
                automatic int home = m_susp[b];
                automatic int c = int'(cmd_code);
                if (m_mode[b] == 0 || m_mode[b] == 1) begin
                    if (mine && c == 1) begin m_mode[b] = 2; m_step[b] = 1; m_what[b] = 0; end
                    else if (mine && c == 8 && m_mode[b] == 1) begin m_mode[b] = 5; m_susp[b] = 0; end
                end else if (m_mode[b] == 2) begin
                    if (is_rst) begin m_mode[b] = home; m_step[b] = 0; m_what[b] = 0; end
                    else if (mine) begin
                        automatic bit ok = 1'b0;
                        if (m_step[b] == 1 && c == 2) begin m_step[b] = 2; ok = 1; end
                        else if (m_step[b] == 2 && c == 3) begin m_step[b] = 3; m_what[b] = 1; ok = 1; end
                        else if (m_step[b] == 2 && c == 4 && m_susp[b] == 0) begin m_step[b] = 3; m_what[b] = 2; ok = 1; end
                        else if (m_step[b] == 2 && c == 5) begin m_mode[b] = 3; m_step[b] = 0; ok = 1; end
                        else if (m_step[b] == 3 && m_what[b] == 1 && c == 6) begin m_mode[b] = 4; m_step[b] = 0; m_what[b] = 0; ok = 1; end
                        else if (m_step[b] == 3 && m_what[b] == 2 && c == 1) begin m_step[b] = 4; ok = 1; end
                        else if (m_step[b] == 4 && c == 2) begin m_step[b] = 5; ok = 1; end
                        else if (m_step[b] == 5 && c == 6) begin m_mode[b] = 5; m_step[b] = 0; m_what[b] = 0; ok = 1; end
                        if (!ok) begin m_mode[b] = home; m_step[b] = 0; m_what[b] = 0; end
                    end
                end else if (m_mode[b] == 3) begin
                    if (is_rst) m_mode[b] = home;
                end else if (m_mode[b] == 4) begin
                    if (op_done[b] || (is_rst && op_timeout[b])) m_mode[b] = home;
                    else if (is_rst || mine) dropped = 1;
                end else if (m_mode[b] == 5) begin
                    if (op_done[b] || (is_rst && op_timeout[b])) begin m_mode[b] = 0; m_susp[b] = 0; end
                    else if (mine && c == 7) begin m_mode[b] = 1; m_susp[b] = 1; end
                    else if (is_rst || mine) dropped = 1;
                end
            end
            m_ign = dropped;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int dut_mode(input int b);
        return int'(bank_mode[b*3 +: 3]);
    endfunction

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int b = 0; b < NB; b++)
                chk(dut_mode(b) == m_mode[b], cur_req, $sformatf("model bank%0d mode", b),
                    dut_mode(b), m_mode[b]);
            chk(int'(cmd_ignored) == m_ign, cur_req, "model ignored", int'(cmd_ignored), m_ign);
        end
    end

    task automatic send(input int code, input int bank);
        cmd_valid = 1'b1;
        cmd_code  = code[3:0];
        cmd_bank  = bank[1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 4'd0;
        cmd_bank  = 2'd0;
    endtask

    task automatic pulse_done(input int bank);
        op_done[bank] = 1'b1;
        @(negedge clk);
        op_done = 4'd0;
    endtask

    task automatic expect_mode(input int bank, input int exp, input string tag);
        chk(dut_mode(bank) == exp, tag, $sformatf("bank%0d mode", bank), dut_mode(bank), exp);
    endtask

    task automatic expect_ign(input int exp, input string tag);
        chk(int'(cmd_ignored) == exp, tag, "cmd_ignored", int'(cmd_ignored), exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;
        // R1 reset state
        for (int b = 0; b < NB; b++) expect_mode(b, 0, "R1");
        expect_ign(0, "R1");
        @(negedge clk);

        // R3 program sequence, R9 completion
        cur_req = "R3";
        send(1, 0); send(2, 0); send(3, 0);
        expect_mode(0, 2, "R3");
        send(6, 0);
        expect_mode(0, 4, "R3");
        cur_req = "R9";
        pulse_done(0);
        expect_mode(0, 0, "R9");

        // R3 reset before the data write, target field ignored (R2)
        cur_req = "R3";
        send(1, 1); send(2, 1); send(3, 1);
        send(0, 3);
        expect_mode(1, 0, "R3");

        // R4 erase, R6 busy drops commands
        cur_req = "R4";
        send(1, 2); send(2, 2); send(4, 2); send(1, 2); send(2, 2); send(6, 2);
        expect_mode(2, 5, "R4");
        cur_req = "R6";
        send(0, 0);
        expect_mode(2, 5, "R6");
        expect_ign(1, "R6");
        @(negedge clk);
        expect_ign(0, "R6");
        send(1, 2);
        expect_mode(2, 5, "R6");
        expect_ign(1, "R6");

        // R8 suspend, R7 failed program from suspend, R5 identify, R10 erase blocked
        cur_req = "R8";
        send(7, 2);
        expect_mode(2, 1, "R8");
        cur_req = "R7";
        send(1, 2); send(2, 2); send(3, 2); send(6, 2);
        expect_mode(2, 4, "R7");
        op_timeout[2] = 1'b1;
        send(0, 0);
        op_timeout = 4'd0;
        expect_mode(2, 1, "R7");
        cur_req = "R5";
        send(1, 2); send(2, 2); send(5, 2);
        expect_mode(2, 3, "R5");
        send(1, 2);
        expect_mode(2, 3, "R5");
        send(0, 1);
        expect_mode(2, 1, "R5");
        cur_req = "R10";
        send(1, 2); send(2, 2); send(4, 2);
        expect_mode(2, 1, "R10");
        cur_req = "R8";
        send(8, 2);
        expect_mode(2, 5, "R8");
        pulse_done(2);
        expect_mode(2, 0, "R8");

        // R4 reset mid erase, R10 out-of-order abort
        cur_req = "R4";
        send(1, 3); send(2, 3); send(4, 3); send(1, 3);
        expect_mode(3, 2, "R4");
        send(0, 0);
        expect_mode(3, 0, "R4");
        cur_req = "R10";
        send(1, 3); send(3, 3);
        expect_mode(3, 0, "R10");

        // R11 isolation, R7 failure reset of program and erase
        cur_req = "R11";
        send(1, 1); send(2, 1); send(3, 1); send(6, 1);
        send(1, 0);
        expect_mode(0, 2, "R11");
        expect_mode(1, 4, "R11");
        expect_ign(0, "R11");
        cur_req = "R7";
        op_timeout[1] = 1'b1;
        send(0, 2);
        op_timeout = 4'd0;
        expect_mode(1, 0, "R7");
        expect_mode(0, 0, "R2");
        send(1, 3); send(2, 3); send(4, 3); send(1, 3); send(2, 3); send(6, 3);
        expect_mode(3, 5, "R7");
        op_timeout[3] = 1'b1;
        send(0, 3);
        op_timeout = 4'd0;
        expect_mode(3, 0, "R7");

        // R2 broadcast to several banks in sequence
        cur_req = "R2";
        send(1, 0); send(1, 3);
        expect_mode(0, 2, "R2");
        expect_mode(3, 2, "R2");
        send(0, 1);
        expect_mode(0, 0, "R2");
        expect_mode(3, 0, "R2");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule